// File: doc/BRIEF.md
# Retransmission Descriptor Manager

This block keeps the bookkeeping for a small ring of transmit packet buffers in a reliable, acknowledged stream from a chip to a host. The data source claims a free buffer, fills it, and the block gives that buffer the next stream packet number. The block then presents buffers to the packet sender, oldest first. Each send carries the value of a 16-bit repetition counter, and the block records that value in the buffer's descriptor.

Acknowledgements arrive as records, each holding a stream packet number and the repetition value that packet carried. Delivery is assumed to stay in order. An acknowledgement that skips past older unacknowledged packets therefore proves those packets were lost. The block reschedules at once every skipped packet whose recorded repetition value is not above the acknowledgement's value, and it advances the repetition counter. Packets already resent after that acknowledgement was produced are left alone.

Acknowledged buffers are released strictly in stream order. A timer on the oldest outstanding packet forces a resend when the host stays silent too long.

Top module: `retx_desc_mgr`

## Requirements
- R1: After reset the ring is empty: `alloc_ready` is 1, `alloc_pkt` is 0 and `tx_valid` is 0.
- R2: Each accepted allocation (`alloc_valid` while `alloc_ready`) takes the next consecutive packet number, starting from 0. That packet is offered once on `tx_*`, carrying the current repetition value (0 after reset).
- R3: While NBUF packets are unreleased, `alloc_ready` is 0 and `alloc_valid` has no effect: `alloc_pkt` does not change and nothing new is offered.
- R4: An accepted acknowledgement for packet N marks every older unacknowledged packet that has a recorded repetition value not above the acknowledgement's value for resend. If it marks at least one packet, the repetition counter increases by one. Resends carry the new value and go out oldest packet first.
- R5: An older unacknowledged packet whose recorded repetition value is above the acknowledgement's value is not resent.
- R6: Buffers are released in stream order, one per cycle, while the oldest unreleased packet is acknowledged. A packet acknowledged ahead of an unacknowledged older one keeps its buffer until the older one is acknowledged.
- R7: An acknowledgement for a packet number that is already released, already acknowledged, or never allocated is ignored. It causes no resend and changes neither the counter nor the ring.
- R8: If the oldest packet has been sent and stays unacknowledged for `timeout_cycles` cycles with no accepted acknowledgement, it is resent. The repetition counter increases by one.
- R9: The 16-bit repetition counter changes by at most one per cycle and never decreases, except when it wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timeout_cycles | input | TOW | Idle cycles before the oldest packet is resent |
| alloc_valid | input | 1 | Data source commits a filled buffer |
| alloc_ready | output | 1 | A free buffer exists |
| alloc_slot | output | log2(NBUF) | Buffer index for the next allocation |
| alloc_pkt | output | SEQW | Packet number the next allocation receives |
| tx_valid | output | 1 | A packet is waiting to be sent |
| tx_ready | input | 1 | Sender takes the offered packet |
| tx_slot | output | log2(NBUF) | Buffer to send |
| tx_pkt | output | SEQW | Stream number of that packet |
| tx_rep | output | 16 | Repetition value to place in the packet |
| ack_valid | input | 1 | Acknowledgement record present |
| ack_pkt | input | SEQW | Acknowledged packet number |
| ack_rep | input | 16 | Repetition value echoed by the host |

## Verification
The bench acknowledges the newest packets of a full ring first. A design that fails to infer loss would leave the skipped packets stalled. A design that reuses the old repetition value would send duplicates that a later stale acknowledgement resends yet again. A stale acknowledgement then probes the repetition filter, and a design with the comparison turned around would produce extra transmissions. The bench also sends acknowledgements for released and unallocated numbers, which must cause neither a resend nor a ring change. It lets the oldest packet time out, which a missing timer would turn into a hang. It also checks that the ring refuses allocations while full and releases buffers only in order.

// File: rtl/retx_desc_mgr.sv
module retx_desc_mgr #(
  parameter int NBUF = 16,
  parameter int SEQW = 32,
  parameter int TOW  = 20,
  localparam int IW   = $clog2(NBUF),
  localparam int REPW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TOW-1:0]  timeout_cycles,
  input  logic            alloc_valid,
  output logic            alloc_ready,
  output logic [IW-1:0]   alloc_slot,
  output logic [SEQW-1:0] alloc_pkt,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [IW-1:0]   tx_slot,
  output logic [SEQW-1:0] tx_pkt,
  output logic [REPW-1:0] tx_rep,
  input  logic            ack_valid,
  input  logic [SEQW-1:0] ack_pkt,
  input  logic [REPW-1:0] ack_rep
);

  logic [SEQW-1:0] head, tail, occ, ack_off;
  logic [REPW-1:0] grep;
  logic [TOW-1:0]  tcnt;
  logic [NBUF-1:0] pend, acked, loss;
  logic [REPW-1:0] rep [NBUF];
  logic [IW-1:0]   tslot, aslot, sel;
  logic            found, ack_ok, new_loss, to_fire, tx_fire, alloc_fire, nonempty;

  assign occ        = head - tail;
  assign nonempty   = occ != '0;
  assign tslot      = tail[IW-1:0];
  assign aslot      = ack_pkt[IW-1:0];
  assign ack_off    = ack_pkt - tail;
  assign ack_ok     = ack_valid && (ack_off < occ) && !acked[aslot];
  assign alloc_ready = occ != SEQW'(NBUF);
  assign alloc_slot = head[IW-1:0];
  assign alloc_pkt  = head;
  assign alloc_fire = alloc_valid && alloc_ready;
  assign to_fire    = nonempty && !pend[tslot] && !acked[tslot] && !ack_ok &&
                      (tcnt == timeout_cycles);

  always_comb begin
    for (int i = 0; i < NBUF; i++) begin
      logic [IW-1:0] off;
      off = IW'(i) - tslot;
      loss[i] = ack_ok && (SEQW'(off) < ack_off) && !acked[i] && (rep[i] <= ack_rep);
    end
  end
  assign new_loss = |(loss & ~pend);

  always_comb begin
    found = 1'b0;
    sel   = '0;
    tx_pkt = tail;
    for (int k = 0; k < NBUF; k++) begin
      logic [IW-1:0] s;
      s = tslot + IW'(k);
      if (!found && (SEQW'(k) < occ) && pend[s] && !acked[s]) begin
        found  = 1'b1;
        sel    = s;
        tx_pkt = tail + SEQW'(k);
      end
    end
  end

  assign tx_valid = found;
  assign tx_slot  = sel;
  assign tx_rep   = grep;
  assign tx_fire  = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      grep  <= '0;
      tcnt  <= '0;
      pend  <= '0;
      acked <= '0;
      for (int i = 0; i < NBUF; i++) rep[i] <= '0;
    end else begin
      if (new_loss || to_fire) grep <= grep + 1'b1;

      if (ack_ok || !nonempty || pend[tslot] || acked[tslot] || to_fire)
        tcnt <= '0;
      else
        tcnt <= tcnt + 1'b1;

      if (tx_fire) rep[sel] <= grep;

      for (int i = 0; i < NBUF; i++) begin
        if (tx_fire && sel == IW'(i)) pend[i] <= 1'b0;
        if (loss[i]) pend[i] <= 1'b1;
        if (to_fire && tslot == IW'(i)) pend[i] <= 1'b1;
        if (ack_ok && aslot == IW'(i)) begin
          pend[i]  <= 1'b0;
          acked[i] <= 1'b1;
        end
        if (nonempty && acked[tslot] && tslot == IW'(i)) acked[i] <= 1'b0;
        if (alloc_fire && head[IW-1:0] == IW'(i)) begin
          pend[i]  <= 1'b1;
          acked[i] <= 1'b0;
        end
      end

      if (nonempty && acked[tslot]) tail <= tail + 1'b1;
      if (alloc_fire) head <= head + 1'b1;
    end
  end

  // R3: occupancy never exceeds the ring
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= SEQW'(NBUF));

  // R3: refused allocation leaves the head alone
  a_r3_refused_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready) |=> (head == $past(head)));

  // R9: counter steps by at most one
  a_r9_rep_step: assert property (@(posedge clk) disable iff (!rst_n)
    (grep == $past(grep)) || (grep == $past(grep) + 1'b1));

  // R6: release is in order, one buffer per cycle
  a_r6_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tail == $past(tail)) || (tail == $past(tail) + 1'b1));

  // R2: nothing is offered from an empty ring
  a_r2_offer_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> nonempty);

  // R7: an ignored acknowledgement never triggers a burst by itself
  a_r7_ignored_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ok && !to_fire) |=> (grep == $past(grep)));

endmodule

// File: tb/test_retx_desc_mgr.sv
module test_retx_desc_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int NBUF = 4;
  localparam int SEQW = 16;
  localparam int TOW  = 12;
  localparam int IW   = $clog2(NBUF);

  logic clk = 0, rst_n = 0;
  logic [TOW-1:0]  timeout_cycles = 12'd200;
  logic            alloc_valid = 0, tx_ready = 1, ack_valid = 0;
  logic [SEQW-1:0] ack_pkt = '0;
  logic [15:0]     ack_rep = '0;
  logic            alloc_ready, tx_valid;
  logic [IW-1:0]   alloc_slot, tx_slot;
  logic [SEQW-1:0] alloc_pkt, tx_pkt;
  logic [15:0]     tx_rep;

  int errors = 0, checks = 0;
  logic [31:0] expq [$];
  string tagq [$];

  retx_desc_mgr #(.NBUF(NBUF), .SEQW(SEQW), .TOW(TOW)) i_retx_desc_mgr (
    .clk, .rst_n, .timeout_cycles, .alloc_valid, .alloc_ready, .alloc_slot,
    .alloc_pkt, .tx_valid, .tx_ready, .tx_slot, .tx_pkt, .tx_rep,
    .ack_valid, .ack_pkt, .ack_rep);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_tx(input string req, input int pkt, input int r);
    expq.push_back({pkt[15:0], r[15:0]});
    tagq.push_back(req);
  endtask

  // monitor: compare every handshake against the scoreboard
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (expq.size() == 0) check("unexpected send", {tx_pkt, tx_rep}, 32'hffffffff);
      else check(tagq.pop_front(), {tx_pkt, tx_rep}, expq.pop_front());
    end
  end

  task automatic alloc();
    @(negedge clk); alloc_valid = 1;
    @(negedge clk); alloc_valid = 0;
  endtask

  task automatic ack(input int pkt, input int r);
    @(negedge clk); ack_valid = 1; ack_pkt = pkt[SEQW-1:0]; ack_rep = r[15:0];
    @(negedge clk); ack_valid = 0;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (expq.size() != 0 && n < 1000) begin @(negedge clk); n++; end
    check({req, " drained"}, expq.size(), 0);
    expq.delete(); tagq.delete();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 alloc_ready", alloc_ready, 1);
    check("R1 alloc_pkt", alloc_pkt, 0);
    check("R1 tx_valid", tx_valid, 0);

    for (int i = 0; i < NBUF; i++) begin
      expect_tx("R2 first send", i, 0);
      alloc();
    end
    drain("R2");
    check("R3 full ready", alloc_ready, 0);
    alloc();
    idle(3);
    check("R3 full alloc_pkt", alloc_pkt, NBUF);
    check("R3 full no send", tx_valid, 0);

    expect_tx("R4 resend oldest", 0, 1);
    expect_tx("R4 resend next", 1, 1);
    ack(2, 0);
    drain("R4");
    check("R6 held behind loss", alloc_ready, 0);

    ack(3, 0);
    idle(5);
    check("R5 stale ack no resend", tx_valid, 0);
    check("R5 queue empty", expq.size(), 0);

    ack(0, 1);
    idle(2);
    check("R6 one freed", alloc_ready, 1);
    ack(1, 1);
    idle(5);
    check("R6 all freed ready", alloc_ready, 1);

    ack(1, 1);
    ack(50, 0);
    idle(4);
    check("R7 ignored no send", tx_valid, 0);
    check("R7 ignored alloc_pkt", alloc_pkt, 4);

    timeout_cycles = 12'd20;
    expect_tx("R2 fresh after burst", 4, 1);
    expect_tx("R8 timeout resend", 4, 2);
    alloc();
    drain("R8");
    timeout_cycles = 12'd200;
    ack(4, 2);

    expect_tx("R2 fresh", 5, 2);
    expect_tx("R2 fresh", 6, 2);
    expect_tx("R2 fresh", 7, 2);
    alloc(); alloc(); alloc();
    drain("R2 batch");
    expect_tx("R4 oldest first", 5, 3);
    expect_tx("R4 then next", 6, 3);
    ack(7, 2);
    drain("R4 second");
    ack(5, 3); ack(6, 3);
    idle(6);
    check("R9 ring empty after acks", alloc_pkt, 8);
    check("R9 ready", alloc_ready, 1);
    expect_tx("R9 counter kept", 8, 3);
    alloc();
    drain("R9");
    check("R7 no extra sends", expq.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule